// File: doc/BRIEF.md
# Accumulator ALU with Coded Functions

This block is the arithmetic and logic unit of a small accumulator machine. It keeps a 16-bit accumulator and three condition flags (zero, carry, sign). Each clock it can take one operation: a 4-bit function code and a second operand. The accumulator is always the left operand. When the function writes a result, the result goes back into the accumulator.

The surrounding datapath picks the second operand and reads the flags for its branch decisions. The block only computes and holds state. No port loads the accumulator directly. After reset the accumulator is zero, so an add of a value loads that value. An AND with zero followed by an OR with a value also loads it.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, and right after it rises, the accumulator reads 0 and all three flags read 0.
- R2: Function code 1 (add) with `op_valid_i` high writes A + operand, modulo 2^16, into A at the next clock edge. Carry becomes the carry out of bit 15.
- R3: Function code 2 (subtract) writes A − operand, modulo 2^16, into A. Carry becomes the borrow: it is 1 exactly when A is below the operand as unsigned numbers.
- R4: Function code 3 (compare) sets zero, carry and sign exactly as subtract would for the same A and operand. A keeps its value.
- R5: Function codes 4, 5 and 6 write A AND operand, A OR operand and A XOR operand into A. Each of them clears carry.
- R6: Function code 7 (shift left) writes A shifted up by one bit into A, with bit 0 set to 0. Carry takes the old bit 15.
- R7: Function code 8 (shift right) writes A shifted down by one bit into A, with bit 15 set to 0. Carry takes the old bit 0.
- R8: Function code 9 (nibble swap) exchanges bits [3:0] with [7:4] and bits [11:8] with [15:12] of A and writes the result into A. It clears carry, and the operand has no effect on it.
- R9: After any of codes 1 to 9, zero is 1 exactly when the 16-bit result is 0, and sign equals bit 15 of the result.
- R10: Function code 0, codes 10 to 15, and any cycle with `op_valid_i` low leave A and all three flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | An operation is presented this cycle |
| func_i | input | 4 | Function code (see R2–R10) |
| operand_i | input | 16 | Right-hand operand |
| acc_o | output | 16 | Accumulator value |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry / borrow / shifted-out bit |
| sign_o | output | 1 | Sign flag (bit 15 of last result) |

## Verification
Some behaviours are checked on every cycle against the previous cycle's ports:
- idle cycles and reserved codes leave all state unchanged;
- compare leaves A unchanged;
- zero and sign agree with the new accumulator after a writing function;
- logic and swap operations clear carry;
- add, subtract and both shifts produce the right next state.

Other behaviours only the bench's sweep can show:
- the compare flags, because after a compare the flags no longer describe A;
- the exact nibble-swap result and the fact that the operand has no effect on it;
- the reset values.

The sweep crosses every function code with accumulator and operand values at the sign, carry and zero boundaries.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int FN_BITS = 4;

    typedef enum logic [FN_BITS-1:0] {
        FN_NOP  = 4'd0,
        FN_ADD  = 4'd1,
        FN_SUB  = 4'd2,
        FN_CMP  = 4'd3,
        FN_AND  = 4'd4,
        FN_OR   = 4'd5,
        FN_XOR  = 4'd6,
        FN_SHL  = 4'd7,
        FN_SHR  = 4'd8,
        FN_SWAP = 4'd9
    } fn_e;

    typedef struct packed {
        logic zero;
        logic carry;
        logic sign;
    } flags_t;

endpackage

// File: rtl/acc_alu_swap.sv
// Exchanges the two nibbles inside every byte of the input word.
module acc_alu_swap #(
    parameter int W = 16
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int NBYTES = W / 8;

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        assign dout[g*8 +: 4]     = din[g*8 + 4 +: 4];
        assign dout[g*8 + 4 +: 4] = din[g*8 +: 4];
    end

endmodule

// File: rtl/acc_alu_datapath.sv
// Combinational function unit: computes the result and carry, and says
// whether the accumulator and/or flags take them.
module acc_alu_datapath
    import acc_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [FN_BITS-1:0] func_i,
    input  logic [W-1:0]       a_i,
    input  logic [W-1:0]       b_i,
    output logic [W-1:0]       res_o,
    output logic               cout_o,
    output logic               wr_acc_o,
    output logic               wr_flg_o
);
    logic [W:0]   sum;
    logic [W:0]   diff;
    logic [W-1:0] swapped;

    assign sum  = {1'b0, a_i} + {1'b0, b_i};
    assign diff = {1'b0, a_i} - {1'b0, b_i};

    acc_alu_swap #(.W(W)) u_swap (
        .din  (a_i),
        .dout (swapped)
    );

    always_comb begin
        res_o    = a_i;
        cout_o   = 1'b0;
        wr_acc_o = 1'b0;
        wr_flg_o = 1'b0;
        case (func_i)
            FN_ADD: begin
                res_o = sum[W-1:0]; cout_o = sum[W];
                wr_acc_o = 1'b1; wr_flg_o = 1'b1;
            end
            FN_SUB: begin
                res_o = diff[W-1:0]; cout_o = diff[W];
                wr_acc_o = 1'b1; wr_flg_o = 1'b1;
            end
            FN_CMP: begin
                res_o = diff[W-1:0]; cout_o = diff[W];
                wr_flg_o = 1'b1;
            end
            FN_AND: begin
                res_o = a_i & b_i; wr_acc_o = 1'b1; wr_flg_o = 1'b1;
            end
            FN_OR: begin
                res_o = a_i | b_i; wr_acc_o = 1'b1; wr_flg_o = 1'b1;
            end
            FN_XOR: begin
                res_o = a_i ^ b_i; wr_acc_o = 1'b1; wr_flg_o = 1'b1;
            end
            FN_SHL: begin
                res_o = {a_i[W-2:0], 1'b0}; cout_o = a_i[W-1];
                wr_acc_o = 1'b1; wr_flg_o = 1'b1;
            end
            FN_SHR: begin
                res_o = {1'b0, a_i[W-1:1]}; cout_o = a_i[0];
                wr_acc_o = 1'b1; wr_flg_o = 1'b1;
            end
            FN_SWAP: begin
                res_o = swapped; wr_acc_o = 1'b1; wr_flg_o = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid_i,
    input  logic [FN_BITS-1:0] func_i,
    input  logic [W-1:0]       operand_i,
    output logic [W-1:0]       acc_o,
    output logic               zero_o,
    output logic               carry_o,
    output logic               sign_o
);
    typedef struct packed {
        logic [W-1:0] acc;
        flags_t       flg;
    } state_t;

    state_t       state_d, state_q;
    logic [W-1:0] res;
    logic         cout;
    logic         wr_acc;
    logic         wr_flg;

    acc_alu_datapath #(.W(W)) u_dp (
        .func_i   (func_i),
        .a_i      (state_q.acc),
        .b_i      (operand_i),
        .res_o    (res),
        .cout_o   (cout),
        .wr_acc_o (wr_acc),
        .wr_flg_o (wr_flg)
    );

    always_comb begin
        state_d = state_q;
        if (op_valid_i) begin
            if (wr_acc) begin
                state_d.acc = res;
            end
            if (wr_flg) begin
                state_d.flg.zero  = (res == '0);
                state_d.flg.carry = cout;
                state_d.flg.sign  = res[W-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign acc_o   = state_q.acc;
    assign zero_o  = state_q.flg.zero;
    assign carry_o = state_q.flg.carry;
    assign sign_o  = state_q.flg.sign;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid_i,
    input logic [3:0]   func_i,
    input logic [W-1:0] operand_i,
    input logic [W-1:0] acc_o,
    input logic         zero_o,
    input logic         carry_o,
    input logic         sign_o
);
    logic legal, writes_acc, clears_carry;
    assign legal        = op_valid_i && (func_i >= 4'd1) && (func_i <= 4'd9);
    assign writes_acc   = legal && (func_i != 4'd3);
    assign clears_carry = op_valid_i && ((func_i == 4'd4) || (func_i == 4'd5) ||
                                         (func_i == 4'd6) || (func_i == 4'd9));

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !legal |=> $stable(acc_o) && $stable(zero_o) && $stable(carry_o) && $stable(sign_o)); // R10
    AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && func_i == 4'd3) |=> $stable(acc_o)); // R4
    AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        writes_acc |=> (zero_o == (acc_o == '0))); // R9
    AST_SIGN_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        writes_acc |=> (sign_o == acc_o[W-1])); // R9
    AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        clears_carry |=> !carry_o); // R5
    AST_ADD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && func_i == 4'd1) |=>
        ({carry_o, acc_o} == ({1'b0, $past(acc_o)} + {1'b0, $past(operand_i)}))); // R2
    AST_SUB_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && func_i == 4'd2) |=>
        (acc_o == $past(acc_o) - $past(operand_i)) && (carry_o == ($past(acc_o) < $past(operand_i)))); // R3
    AST_SHL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && func_i == 4'd7) |=>
        (acc_o == ($past(acc_o) << 1)) && (carry_o == $past(acc_o[W-1]))); // R6
    AST_SHR_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && func_i == 4'd8) |=>
        (acc_o == ($past(acc_o) >> 1)) && (carry_o == $past(acc_o[0]))); // R7

endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_acc_alu_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid_i (op_valid_i),
    .func_i     (func_i),
    .operand_i  (operand_i),
    .acc_o      (acc_o),
    .zero_o     (zero_o),
    .carry_o    (carry_o),
    .sign_o     (sign_o)
);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid_i = 1'b0;
    logic [3:0]  func_i = 4'd0;
    logic [15:0] operand_i = 16'd0;
    logic [15:0] acc_o;
    logic        zero_o, carry_o, sign_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [15:0] ma = 16'd0;
    logic        mz = 1'b0, mc = 1'b0, ms = 1'b0;
    logic [15:0] vals [8];

    always #5 clk = ~clk;

    acc_alu u_acc_alu (
        .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .func_i(func_i),
        .operand_i(operand_i), .acc_o(acc_o), .zero_o(zero_o),
        .carry_o(carry_o), .sign_o(sign_o)
    );

    function automatic string tag_of(int f);
        case (f)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4, 5, 6: return "R5";
            7: return "R6";
            8: return "R7";
            9: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(int f, logic [15:0] b, bit v);
        logic [16:0] s;
        logic [15:0] r;
        logic        c;
        bit          wa, wf;
        string       t;
        @(negedge clk);
        op_valid_i = v; func_i = 4'(f); operand_i = b;
        r = ma; c = 1'b0; wa = 1'b0; wf = 1'b0;
        case (f)
            1: begin s = {1'b0, ma} + {1'b0, b}; r = s[15:0]; c = s[16]; wa = 1; wf = 1; end
            2: begin r = ma - b; c = (ma < b); wa = 1; wf = 1; end
            3: begin r = ma - b; c = (ma < b); wf = 1; end
            4: begin r = ma & b; wa = 1; wf = 1; end
            5: begin r = ma | b; wa = 1; wf = 1; end
            6: begin r = ma ^ b; wa = 1; wf = 1; end
            7: begin r = ma << 1; c = ma[15]; wa = 1; wf = 1; end
            8: begin r = ma >> 1; c = ma[0]; wa = 1; wf = 1; end
            9: begin r = ((ma & 16'h0F0F) << 4) | ((ma & 16'hF0F0) >> 4); wa = 1; wf = 1; end
            default: ;
        endcase
        if (v && wf) begin mz = (r == 16'd0); mc = c; ms = r[15]; end
        if (v && wa) ma = r;
        @(posedge clk);
        #1;
        t = v ? tag_of(f) : "R10";
        check(t, "acc", acc_o, ma);
        check(t, "carry", {15'd0, carry_o}, {15'd0, mc});
        check((v && wf) ? "R9" : t, "zero", {15'd0, zero_o}, {15'd0, mz});
        check((v && wf) ? "R9" : t, "sign", {15'd0, sign_o}, {15'd0, ms});
        op_valid_i = 1'b0;
    endtask

    task automatic load_acc(logic [15:0] x);
        apply(4, 16'h0000, 1'b1);
        apply(5, x, 1'b1);
    endtask

    initial begin
        vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF; vals[3] = 16'h8000;
        vals[4] = 16'hFFFF; vals[5] = 16'h00FF; vals[6] = 16'h1234; vals[7] = 16'hF00F;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "acc in reset", acc_o, 16'd0);
        check("R1", "flags in reset", {13'd0, zero_o, carry_o, sign_o}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", "acc after reset", acc_o, 16'd0);
        check("R1", "flags after reset", {13'd0, zero_o, carry_o, sign_o}, 16'd0);
        for (int f = 0; f < 16; f++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    load_acc(vals[i]);
                    if (f >= 4 && f <= 9) apply(1, 16'h0000, 1'b1);
                    apply(f, vals[j], 1'b1);
                end
            end
        end
        // R10: a valid-low cycle after a carry-setting add must change nothing
        load_acc(16'hFFFF);
        apply(1, 16'h0002, 1'b1);
        for (int f = 1; f < 10; f++) apply(f, 16'h5A5A, 1'b0);
        // R8: swap result independent of operand
        load_acc(16'hA5C3);
        apply(9, 16'hFFFF, 1'b1);
        apply(9, 16'h0000, 1'b1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule